// File: doc/BRIEF.md
# FSK Subcarrier Run-Length Bit Demodulator

This block recovers a serial bit stream from the sampled envelope of a 125 kHz reader field that carries a two-tone FSK response. Each 8-bit envelope sample is sliced to a single level. The number of samples between successive rising edges of that level is measured. Each measured period is labelled as the fast subcarrier (fc/8) or the slow subcarrier (fc/10). Runs of equal labels are then turned into a number of whole bits. The divisor used depends on which subcarrier the run belongs to.

Samples arrive through a valid/ready handshake. Recovered bits leave as a one-cycle strobe with a data bit. When one run yields several bits, the block emits them on back-to-back cycles and holds off new samples until the burst is nearly drained. Buffering the samples, controlling the converter, generating the carrier and decoding the frame are left to other blocks.

Top module: `fsk_run_demod`

## Requirements
- R1: After a synchronous reset, `bit_valid` is 0 and `smp_ready` is 1 on the following cycle, and no bits are pending.
- R2: A sample value of 126 or less slices to low, and a value of 127 or more slices to high.
- R3: No period is measured before the first low-to-high transition of the sliced level. Every later low-to-high transition closes one period and opens the next. A high level on the first sample after reset is not a transition.
- R4: A period of at most 8 samples is labelled fast (class 1), and a period of 9 or more samples is labelled slow (class 0). The period counter saturates at 255, so an overlong period is labelled slow.
- R5: Consecutive equal labels form a run. A run produces output only when a label of the other class arrives.
- R6: A fast run of length L yields floor((L+1)/7) bits. A slow run of length L yields floor((L+1)/6) bits.
- R7: A yield of 0 or 1 emits exactly one bit. A yield from 2 to 12 emits that many bits. A yield above 12 emits no bits.
- R8: Every emitted bit is the inverse of its run's class: a fast run emits 0 and a slow run emits 1.
- R9: The bits of one run appear on consecutive cycles, each with a one-cycle `bit_valid`. `smp_ready` is low exactly while more than one bit of a burst remains to be shown.
- R10: A reset in mid-stream discards the edge lock and the open run, so decoding restarts from a fresh first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Envelope sample offered |
| smp_data | input | 8 | Envelope sample value |
| smp_ready | output | 1 | Block accepts the offered sample this cycle |
| bit_valid | output | 1 | Recovered bit strobe |
| bit_data | output | 1 | Recovered bit value |

## Verification
A wrong edge lock or period count moves a label across the fast/slow boundary. That shows up as a missing, surplus or inverted bit at the next class change, so it appears only one run later, up to a hundred samples afterwards. A wrong pending-bit count is visible within a single cycle through `smp_ready` and `bit_valid`. The bench therefore compares the handshake and the output on every cycle against a behavioural model. It also checks the whole bit sequence of each directed pattern after the pattern has been drained.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

   typedef enum logic {
      CLS_SLOW = 1'b0,
      CLS_FAST = 1'b1
   } sub_cls_e;

   typedef struct packed {
      logic     valid;
      sub_cls_e cls;
   } period_ev_t;

endpackage

// File: rtl/fskd_period_meter.sv
module fskd_period_meter
   import fskd_pkg::*;
#(
   parameter int SMP_W     = 8,
   parameter int THRESH    = 127,
   parameter int PER_W     = 8,
   parameter int SHORT_MAX = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic [SMP_W-1:0] smp,
   output period_ev_t       ev
);
   localparam logic [PER_W-1:0] PER_SAT   = {PER_W{1'b1}};
   localparam logic [PER_W-1:0] PER_FAST  = PER_W'(SHORT_MAX);

   logic             lvl;
   logic             have_prev;
   logic             prev_lvl;
   logic             locked;
   logic [PER_W-1:0] cnt;
   logic             rise;

   generate
      if (THRESH <= 0) begin : g_all_high
         assign lvl = 1'b1;
      end else begin : g_compare
         assign lvl = (smp >= SMP_W'(THRESH));
      end
   endgenerate

   assign rise = take && have_prev && !prev_lvl && lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_prev <= 1'b0;
         prev_lvl  <= 1'b0;
         locked    <= 1'b0;
         cnt       <= '0;
      end else if (take) begin
         have_prev <= 1'b1;
         prev_lvl  <= lvl;
         if (rise) begin
            locked <= 1'b1;
            cnt    <= PER_W'(1);
         end else if (cnt != PER_SAT) begin
            cnt <= cnt + PER_W'(1);
         end
      end
   end

   always_comb begin
      ev.valid = rise && locked;
      ev.cls   = (cnt <= PER_FAST) ? CLS_FAST : CLS_SLOW;
   end

endmodule

// File: rtl/fskd_run_grouper.sv
module fskd_run_grouper
   import fskd_pkg::*;
#(
   parameter int RUN_W     = 8,
   parameter int SHORT_DIV = 7,
   parameter int LONG_DIV  = 6,
   parameter int MAX_BITS  = 12,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  period_ev_t       ev,
   output logic [CNT_W-1:0] burst_n,
   output logic             burst_val
);
   localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};
   localparam logic [RUN_W:0]   DIV_F   = (RUN_W+1)'(SHORT_DIV);
   localparam logic [RUN_W:0]   DIV_S   = (RUN_W+1)'(LONG_DIV);
   localparam logic [RUN_W:0]   CAP     = (RUN_W+1)'(MAX_BITS);

   logic             have_run;
   sub_cls_e         run_cls;
   logic [RUN_W-1:0] run_len;
   logic [RUN_W:0]   len_p1;
   logic [RUN_W:0]   yield;
   logic             closes;

   assign closes = ev.valid && have_run && (ev.cls != run_cls);
   assign len_p1 = {1'b0, run_len} + (RUN_W+1)'(1);
   assign yield  = (run_cls == CLS_FAST) ? (len_p1 / DIV_F) : (len_p1 / DIV_S);

   always_comb begin
      burst_val = ~run_cls;
      if (!closes)
         burst_n = '0;
      else if (yield <= (RUN_W+1)'(1))
         burst_n = CNT_W'(1);
      else if (yield <= CAP)
         burst_n = yield[CNT_W-1:0];
      else
         burst_n = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         have_run <= 1'b0;
         run_cls  <= CLS_SLOW;
         run_len  <= '0;
      end else if (ev.valid) begin
         if (!have_run || closes) begin
            have_run <= 1'b1;
            run_cls  <= ev.cls;
            run_len  <= RUN_W'(1);
         end else if (run_len != RUN_SAT) begin
            run_len <= run_len + RUN_W'(1);
         end
      end
   end

endmodule

// File: rtl/fskd_bit_burst.sv
module fskd_bit_burst #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_n,
   input  logic             load_val,
   output logic             room,
   output logic             bit_valid,
   output logic             bit_data
);
   logic [CNT_W-1:0] rem;
   logic             val;

   always_ff @(posedge clk) begin
      if (rst) begin
         rem <= '0;
         val <= 1'b0;
      end else if (load && (load_n != '0)) begin
         rem <= load_n;
         val <= load_val;
      end else if (rem != '0) begin
         rem <= rem - CNT_W'(1);
      end
   end

   assign room      = (rem <= CNT_W'(1));
   assign bit_valid = (rem != '0);
   assign bit_data  = val;

endmodule

// File: rtl/fsk_run_demod.sv
module fsk_run_demod
   import fskd_pkg::*;
#(
   parameter int SMP_W     = 8,
   parameter int THRESH    = 127,
   parameter int PER_W     = 8,
   parameter int SHORT_MAX = 8,
   parameter int RUN_W     = 8,
   parameter int SHORT_DIV = 7,
   parameter int LONG_DIV  = 6,
   parameter int MAX_BITS  = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             smp_ready,
   output logic             bit_valid,
   output logic             bit_data
);
   localparam int CNT_W = $clog2(MAX_BITS + 1);

   generate
      if (SHORT_MAX < 2 || SHORT_MAX >= (1 << PER_W) - 1) begin : g_bad_short
         $error("SHORT_MAX must lie inside the period counter range");
      end
      if (SHORT_DIV < 1 || LONG_DIV < 1) begin : g_bad_div
         $error("run divisors must be positive");
      end
      if (MAX_BITS < 2 || MAX_BITS >= (1 << RUN_W)) begin : g_bad_cap
         $error("MAX_BITS out of range");
      end
      if (THRESH >= (1 << SMP_W)) begin : g_bad_thr
         $error("THRESH exceeds sample range");
      end
   endgenerate

   logic             take;
   period_ev_t       ev;
   logic [CNT_W-1:0] burst_n;
   logic             burst_val;
   logic             room;

   assign take      = smp_valid && room;
   assign smp_ready = room;

   fskd_period_meter #(
      .SMP_W(SMP_W), .THRESH(THRESH), .PER_W(PER_W), .SHORT_MAX(SHORT_MAX)
   ) u_meter (
      .clk(clk), .rst(rst), .take(take), .smp(smp_data), .ev(ev)
   );

   fskd_run_grouper #(
      .RUN_W(RUN_W), .SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV),
      .MAX_BITS(MAX_BITS), .CNT_W(CNT_W)
   ) u_group (
      .clk(clk), .rst(rst), .ev(ev), .burst_n(burst_n), .burst_val(burst_val)
   );

   fskd_bit_burst #(
      .CNT_W(CNT_W)
   ) u_burst (
      .clk(clk), .rst(rst), .load(take), .load_n(burst_n), .load_val(burst_val),
      .room(room), .bit_valid(bit_valid), .bit_data(bit_data)
   );

endmodule

// File: rtl/fskd_checker.sv
module fskd_checker #(
   parameter int MAX_BITS = 12
) (
   input logic clk,
   input logic rst,
   input logic smp_valid,
   input logic smp_ready,
   input logic bit_valid,
   input logic bit_data
);
   localparam int LW = $clog2(MAX_BITS + 2);

   logic [LW-1:0] shown;

   always_ff @(posedge clk) begin
      if (rst)
         shown <= '0;
      else if (smp_valid && smp_ready)
         shown <= '0;
      else if (bit_valid && shown != {LW{1'b1}})
         shown <= shown + LW'(1);
   end

   // R1: reset leaves the output idle and the input open
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!bit_valid && smp_ready));

   // R9: a stall means further bits are still pending
   a_r9_stall_continues: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && !smp_ready) |=> bit_valid);

   // R9: input is only held off while bits are being shown
   a_r9_stall_needs_burst: assert property (@(posedge clk) disable iff (rst)
      !smp_ready |-> bit_valid);

   // R8: bits of one burst share a value
   a_r8_burst_value: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && !smp_ready) |=> $stable(bit_data));

   // R7: no burst exceeds the bit cap
   a_r7_burst_cap: assert property (@(posedge clk) disable iff (rst)
      bit_valid |-> (shown < LW'(MAX_BITS)));

endmodule

bind fsk_run_demod fskd_checker #(.MAX_BITS(MAX_BITS)) u_chk (
   .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
   .bit_valid(bit_valid), .bit_data(bit_data)
);

// File: tb/fsk_run_demod_test.sv
module fsk_run_demod_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       smp_valid = 1'b0;
   logic [7:0] smp_data = 8'd0;
   logic       smp_ready;
   logic       bit_valid;
   logic       bit_data;

   always #2 clk = ~clk;

   fsk_run_demod uut (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_ready(smp_ready), .bit_valid(bit_valid), .bit_data(bit_data)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   logic  last_acc;
   bit    done = 0;

   // behavioural reference
   bit   q[$];
   bit   obs[$];
   bit   m_have_prev, m_prev, m_locked, m_have_run, m_run_cls;
   int   m_idx, m_last, m_run_len;

   function automatic void model_clear();
      q.delete(); obs.delete();
      m_have_prev = 0; m_prev = 0; m_locked = 0; m_have_run = 0;
      m_run_cls = 0; m_idx = 0; m_last = 0; m_run_len = 0;
   endfunction

   function automatic void model_label(bit cls);
      if (!m_have_run) begin
         m_have_run = 1; m_run_cls = cls; m_run_len = 1;
      end else if (cls == m_run_cls) begin
         if (m_run_len < 255) m_run_len++;
      end else begin
         int k = m_run_cls ? (m_run_len + 1) / 7 : (m_run_len + 1) / 6;
         int nb = (k <= 1) ? 1 : ((k <= 12) ? k : 0);
         for (int i = 0; i < nb; i++) q.push_back(!m_run_cls);
         m_run_cls = cls; m_run_len = 1;
      end
   endfunction

   function automatic void model_sample(logic [7:0] d);
      bit lv = (d >= 8'd127);
      if (m_have_prev && !m_prev && lv) begin
         if (m_locked) begin
            int per = m_idx - m_last;
            if (per > 255) per = 255;
            model_label(per <= 8);
         end
         m_locked = 1;
         m_last = m_idx;
      end
      m_prev = lv; m_have_prev = 1; m_idx++;
   endfunction

   task automatic fail_line(string req, string what, int act, int exp);
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
   endtask

   task automatic step(input logic v, input logic [7:0] d);
      bit ev, er;
      @(negedge clk);
      er = (q.size() <= 1);
      ev = (q.size() > 0);
      n_cmp++;
      if (smp_ready !== er)
         fail_line(cur_req, "smp_ready", smp_ready, er);
      else if (bit_valid !== ev)
         fail_line(cur_req, "bit_valid", bit_valid, ev);
      else if (ev && bit_data !== q[0])
         fail_line(cur_req, "bit_data", bit_data, q[0]);
      if (bit_valid === 1'b1) obs.push_back(bit_data);
      smp_valid = v;
      smp_data  = d;
      last_acc  = v && er;
      @(posedge clk);
      if (q.size() > 0) void'(q.pop_front());
      if (last_acc) model_sample(d);
   endtask

   task automatic send(input logic [7:0] d);
      do step(1'b1, d); while (!last_acc);
   endtask

   task automatic send_period(input int p, input int n, input logic [7:0] hi,
                              input logic [7:0] lo);
      for (int r = 0; r < n; r++) begin
         for (int i = 0; i < (p + 1) / 2; i++) send(hi);
         for (int i = 0; i < p - (p + 1) / 2; i++) send(lo);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      n_cmp++;
      if (bit_valid !== 1'b0 || smp_ready !== 1'b1)
         fail_line("R1", "idle after reset (valid,ready)", {bit_valid, smp_ready}, 1);
   endtask

   task automatic drain_and_check(string req, bit exp[$]);
      for (int i = 0; i < 20; i++) step(1'b0, 8'd0);
      n_cmp++;
      if (obs.size() != exp.size()) begin
         fail_line(req, "bit count", obs.size(), exp.size());
      end else begin
         for (int i = 0; i < exp.size(); i++)
            if (obs[i] != exp[i]) begin
               fail_line(req, $sformatf("bit %0d", i), obs[i], exp[i]);
               break;
            end
      end
      obs.delete();
   endtask

   // short pattern: 4 fast, 3 slow, 3 fast sent -> bits 0,1
   task automatic pat_small(input logic [7:0] hi, input logic [7:0] lo);
      send(lo);
      send_period(8, 4, hi, lo);
      send_period(10, 3, hi, lo);
      send_period(8, 3, hi, lo);
   endtask

   initial begin
      bit e[$];
      model_clear();
      repeat (3) @(posedge clk);
      cur_req = "R1";
      do_reset();

      // R3: leading high samples give no edge before the first rising edge
      cur_req = "R3";
      for (int i = 0; i < 10; i++) send(8'd200);
      pat_small(8'd200, 8'd20);
      e = '{0, 1};
      drain_and_check("R3", e);

      // R2: threshold boundary values 127 high, 126 low
      do_reset();
      cur_req = "R2";
      pat_small(8'd127, 8'd126);
      e = '{0, 1};
      drain_and_check("R2", e);

      // R6 R8: 12 fast -> 1 bit 0, 12 slow -> 2 bits 1
      do_reset();
      cur_req = "R6";
      send(8'd10);
      send_period(8, 12, 8'd220, 8'd10);
      send_period(10, 12, 8'd220, 8'd10);
      send_period(8, 2, 8'd220, 8'd10);
      e = '{0, 1, 1};
      drain_and_check("R6,R8", e);

      // R7 R9: 84 fast -> 12 zeros, 6 slow -> one 1, 91 fast -> none
      do_reset();
      cur_req = "R9";
      send(8'd0);
      send_period(8, 84, 8'd255, 8'd0);
      send_period(10, 6, 8'd255, 8'd0);
      send_period(8, 91, 8'd255, 8'd0);
      send_period(10, 1, 8'd255, 8'd0);
      send_period(8, 1, 8'd255, 8'd0);
      e = '{0,0,0,0,0,0,0,0,0,0,0,0,1};
      drain_and_check("R7", e);

      // R4: 8 versus 9 sample boundary
      do_reset();
      cur_req = "R4";
      send(8'd5);
      send_period(8, 6, 8'd180, 8'd5);
      send_period(9, 6, 8'd180, 8'd5);
      send_period(8, 2, 8'd180, 8'd5);
      e = '{0, 1};
      drain_and_check("R4", e);

      // R4: saturated 300-sample period labelled slow
      do_reset();
      send(8'd5);
      send_period(8, 13, 8'd180, 8'd5);
      send_period(300, 1, 8'd180, 8'd5);
      send_period(8, 2, 8'd180, 8'd5);
      e = '{0, 0, 1};
      drain_and_check("R4", e);

      // R5: a run with no class change emits nothing
      do_reset();
      cur_req = "R5";
      send(8'd5);
      send_period(8, 20, 8'd180, 8'd5);
      e = '{};
      drain_and_check("R5", e);

      // R10: reset mid-stream then a fresh pattern
      send_period(10, 1, 8'd180, 8'd5);
      cur_req = "R10";
      do_reset();
      send(8'd180);
      pat_small(8'd180, 8'd5);
      e = '{0, 1};
      drain_and_check("R10", e);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule